// File: doc/BRIEF.md
# Triggered Single-Unit DMA Channel Engine

This block is the sequencer of one DMA channel in which every accepted trigger moves exactly one data unit. A trigger pulse is held in a pending flag. When the engine is idle and the flag is set, it reads the channel's control record from a descriptor RAM and clears the flag, so a later trigger can be held while the unit is still in flight. The record is then checked. If the channel is runnable, the engine can first read a pointer at the source address to find the real data location. It then reads one unit of 8, 16 or 32 bits into an internal buffer and writes that buffer to the destination.

After the write completes, the engine works out the new addresses and the count less one. It writes the whole record back to the descriptor RAM in a single cycle. When that new count is zero it raises a one-cycle interrupt. Moving N units therefore takes N triggers.

The descriptor RAM is a single wide word with a one-cycle read latency. The memory side is a request/ready master that returns read data least-significant-byte aligned.

Top module: `dma_unit_engine`

## Requirements
- R1: A trigger pulse sets a pending flag. A trigger that arrives while the flag is already set merges into it, so each set flag leads to exactly one descriptor fetch. `desc_rd_en_o` is high for exactly one cycle per fetch.
- R2: Descriptor fetch timing:
  - The descriptor fetch is requested in the cycle after the trigger is sampled.
  - The pending flag is cleared one cycle after the fetch request.
  - A trigger sampled while the unit is still in flight leads to one more unit after the current one.
- R3: The record is abandoned when any of these holds: the enable bit is 0, the burst-mode bit is 1, or the count is 0. An abandoned record causes no memory access, no write-back and no interrupt.
- R4: Direct source transfer:
  - With source-type 0 the engine reads one unit at the source address and writes it to the destination address.
  - Size field 1 selects 16 bits and size field 2 selects 32 bits. Every other value selects 8 bits.
  - `mem_size_o` carries 0 for 8 bits, 1 for 16 bits and 2 for 32 bits.
  - No bytes beyond the unit are written.
- R5: With source-type 1 the engine first reads a pointer at the source address: 16 bits wide when the pointer-width bit is 1, and 8 bits otherwise. It zero-extends that value and uses it as the address from which the unit is read.
- R6: Address update after each unit:
  - Each side has a 2-bit address mode. Mode 1 advances the stored address by the unit size in bytes (1, 2 or 4).
  - Modes 0, 2 and 3 keep the address fixed.
  - In pointer mode the stored source address is the pointer location, and that is the address that advances.
- R7: After every unit the whole record is written back in one cycle.
  - The count is reduced by one and the two addresses carry their updated values.
  - All control bits are unchanged.
  - Record layout, from bit 0 upward:
    - bit 0: burst-mode
    - bit 1: enable
    - bit 2: source-type
    - bit 3: pointer-width
    - bits 6:4: size
    - bits 8:7: source mode
    - bits 10:9: destination mode
    - then the count (CNT_W bits), the source address (ADDR_W bits) and the destination address (ADDR_W bits).
- R8: `irq_o` pulses for one cycle, in the write-back cycle, when the new count is zero, and at no other time.
- R9: `busy_o` is 1 from the first memory request of a unit until its destination write is accepted, and 0 otherwise. No memory request is made while `busy_o` is 0.
- R10: Once a memory request is raised, the request, address, direction and size stay stable until `mem_ready_i` accepts it.
- R11: After reset the engine is idle. No fetch, memory request, write-back, busy or interrupt is active until a trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Transfer trigger, sampled each cycle |
| desc_rd_en_o | output | 1 | Descriptor read request; data is due one cycle later |
| desc_rdata_i | input | REC_W | Control record read from the descriptor RAM |
| desc_wr_en_o | output | 1 | Descriptor write-back strobe |
| desc_wdata_o | output | REC_W | Updated control record |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_size_o | output | 2 | Access size: 0 for a byte, 1 for a halfword, 2 for a word |
| mem_wdata_o | output | 32 | Write data, LSB aligned |
| mem_rdata_i | input | 32 | Read data, LSB aligned, valid with ready |
| mem_ready_i | input | 1 | Completes the current request |
| busy_o | output | 1 | Data movement in progress |
| irq_o | output | 1 | Count-exhausted interrupt pulse |

## Verification
The assertions assume the following about the environment:
- The descriptor RAM returns the record exactly one cycle after `desc_rd_en_o`.
- The memory raises `mem_ready_i` only while a request is pending.
- `trig_i` is a synchronous level sampled at the clock.

The bench keeps within these assumptions. Its RAM model answers every fetch on the next edge. Its memory model derives ready from the pending request with one wait state, and it changes the trigger only on falling edges. Under these conditions, the hold-until-ready, busy-covers-request and interrupt-only-on-write-back properties can be judged on the engine alone.

// File: rtl/dma_unit_pkg.sv
package dma_unit_pkg;

  localparam int DATA_W = 32;
  localparam int CTL_W  = 11;

  // control bit positions inside a record
  localparam int F_BURST = 0;
  localparam int F_EN    = 1;
  localparam int F_STYPE = 2;
  localparam int F_PTR16 = 3;
  localparam int F_USIZE = 4;
  localparam int F_SMODE = 7;
  localparam int F_DMODE = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_DECIDE, ST_PTR, ST_READ, ST_WRITE, ST_STORE
  } seq_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bus_size_e;

  function automatic bus_size_e unit_bus_size(input logic [2:0] code);
    case (code)
      3'd1:    return SZ_HALF;
      3'd2:    return SZ_WORD;
      default: return SZ_BYTE;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input bus_size_e sz);
    case (sz)
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input bus_size_e sz);
    case (sz)
      SZ_HALF: return 32'h0000_FFFF;
      SZ_WORD: return 32'hFFFF_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic advances(input logic [1:0] mode);
    return mode == 2'd1;
  endfunction

endpackage

// File: rtl/dma_trig_latch.sv
module dma_trig_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic clear_i,
  output logic pending_o
);

  // a new trigger wins over a clear in the same cycle, so none is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending_o <= 1'b0;
    else if (trig_i)  pending_o <= 1'b1;
    else if (clear_i) pending_o <= 1'b0;
  end

endmodule

// File: rtl/dma_rec_update.sv
module dma_rec_update import dma_unit_pkg::*; #(
  parameter  int ADDR_W = 16,
  parameter  int CNT_W  = 12,
  localparam int REC_W  = CTL_W + CNT_W + 2*ADDR_W
) (
  input  logic [REC_W-1:0]  rec_i,
  output logic [REC_W-1:0]  rec_next_o,
  output logic              runnable_o,
  output logic              last_o,
  output logic              stype_o,
  output logic              ptr16_o,
  output bus_size_e         usize_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);

  localparam int CNT_LO = CTL_W;
  localparam int SRC_LO = CTL_W + CNT_W;
  localparam int DST_LO = CTL_W + CNT_W + ADDR_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_next;
  logic [2:0]        step;
  logic [ADDR_W-1:0] side_addr [2];
  logic [ADDR_W-1:0] side_next [2];
  logic [1:0]        side_mode [2];

  assign cnt          = rec_i[CNT_LO +: CNT_W];
  assign usize_o      = unit_bus_size(rec_i[F_USIZE +: 3]);
  assign step         = size_bytes(usize_o);
  assign side_addr[0] = rec_i[SRC_LO +: ADDR_W];
  assign side_addr[1] = rec_i[DST_LO +: ADDR_W];
  assign side_mode[0] = rec_i[F_SMODE +: 2];
  assign side_mode[1] = rec_i[F_DMODE +: 2];

  for (genvar g = 0; g < 2; g++) begin : g_side
    assign side_next[g] = advances(side_mode[g]) ? side_addr[g] + ADDR_W'(step)
                                                 : side_addr[g];
  end

  assign cnt_next   = cnt - CNT_W'(1);
  assign rec_next_o = {side_next[1], side_next[0], cnt_next, rec_i[CTL_W-1:0]};
  assign runnable_o = rec_i[F_EN] && !rec_i[F_BURST] && (cnt != '0);
  assign last_o     = (cnt_next == '0);
  assign stype_o    = rec_i[F_STYPE];
  assign ptr16_o    = rec_i[F_PTR16];
  assign src_o      = side_addr[0];
  assign dst_o      = side_addr[1];

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl import dma_unit_pkg::*; #(
  parameter  int ADDR_W = 16,
  parameter  int CNT_W  = 12,
  localparam int REC_W  = CTL_W + CNT_W + 2*ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending_i,
  input  logic [REC_W-1:0]  desc_rdata_i,
  input  logic              runnable_i,
  input  logic              last_i,
  input  logic              stype_i,
  input  logic              ptr16_i,
  input  bus_size_e         usize_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [REC_W-1:0]  rec_next_i,
  output logic [REC_W-1:0]  rec_o,
  output logic              desc_rd_en_o,
  output logic              desc_wr_en_o,
  output logic [REC_W-1:0]  desc_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output bus_size_e         mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              fetch_done_o,
  output logic              abandon_o
);

  seq_state_e        state_q, state_d;
  logic [REC_W-1:0]  rec_q;
  logic [ADDR_W-1:0] rd_src_q;
  logic [DATA_W-1:0] buf_q;

  always_comb begin
    state_d      = state_q;
    desc_rd_en_o = 1'b0;
    desc_wr_en_o = 1'b0;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = src_i;
    mem_size_o   = usize_i;
    irq_o        = 1'b0;
    fetch_done_o = 1'b0;
    abandon_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pending_i) begin
          desc_rd_en_o = 1'b1;
          state_d      = ST_LOAD;
        end
      end
      ST_LOAD: begin
        fetch_done_o = 1'b1;
        state_d      = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (!runnable_i) begin
          abandon_o = 1'b1;
          state_d   = ST_IDLE;
        end else if (stype_i) begin
          state_d = ST_PTR;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_PTR: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_i;
        mem_size_o = ptr16_i ? SZ_HALF : SZ_BYTE;
        if (mem_ready_i) state_d = ST_READ;
      end
      ST_READ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = rd_src_q;
        mem_size_o = usize_i;
        if (mem_ready_i) state_d = ST_WRITE;
      end
      ST_WRITE: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = dst_i;
        mem_size_o = usize_i;
        if (mem_ready_i) state_d = ST_STORE;
      end
      ST_STORE: begin
        desc_wr_en_o = 1'b1;
        irq_o        = last_i;
        state_d      = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rec_q    <= '0;
      rd_src_q <= '0;
      buf_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOAD)   rec_q    <= desc_rdata_i;
      if (state_q == ST_DECIDE) rd_src_q <= src_i;
      if (state_q == ST_PTR && mem_ready_i)
        rd_src_q <= ADDR_W'(mem_rdata_i & size_mask(mem_size_o));
      if (state_q == ST_READ && mem_ready_i)
        buf_q <= mem_rdata_i & size_mask(usize_i);
    end
  end

  assign rec_o        = rec_q;
  assign desc_wdata_o = rec_next_i;
  assign mem_wdata_o  = buf_q;
  assign busy_o       = (state_q == ST_PTR) || (state_q == ST_READ) || (state_q == ST_WRITE);

endmodule

// File: rtl/dma_unit_engine.sv
module dma_unit_engine import dma_unit_pkg::*; #(
  parameter  int ADDR_W = 16,
  parameter  int CNT_W  = 12,
  localparam int REC_W  = CTL_W + CNT_W + 2*ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  output logic              desc_rd_en_o,
  input  logic [REC_W-1:0]  desc_rdata_i,
  output logic              desc_wr_en_o,
  output logic [REC_W-1:0]  desc_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              irq_o
);

  // internal events, named so the checker can observe them
  logic              pending_w;
  logic              fetch_done_w;
  logic              abandon_w;
  logic [REC_W-1:0]  rec_w;
  logic [REC_W-1:0]  rec_next_w;
  logic              runnable_w;
  logic              last_w;
  logic              stype_w;
  logic              ptr16_w;
  bus_size_e         usize_w;
  bus_size_e         mem_size_w;
  logic [ADDR_W-1:0] src_w;
  logic [ADDR_W-1:0] dst_w;

  dma_trig_latch u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_i),
    .clear_i   (fetch_done_w),
    .pending_o (pending_w)
  );

  dma_rec_update #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_upd (
    .rec_i      (rec_w),
    .rec_next_o (rec_next_w),
    .runnable_o (runnable_w),
    .last_o     (last_w),
    .stype_o    (stype_w),
    .ptr16_o    (ptr16_w),
    .usize_o    (usize_w),
    .src_o      (src_w),
    .dst_o      (dst_w)
  );

  dma_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pending_i    (pending_w),
    .desc_rdata_i (desc_rdata_i),
    .runnable_i   (runnable_w),
    .last_i       (last_w),
    .stype_i      (stype_w),
    .ptr16_i      (ptr16_w),
    .usize_i      (usize_w),
    .src_i        (src_w),
    .dst_i        (dst_w),
    .rec_next_i   (rec_next_w),
    .rec_o        (rec_w),
    .desc_rd_en_o (desc_rd_en_o),
    .desc_wr_en_o (desc_wr_en_o),
    .desc_wdata_o (desc_wdata_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_size_o   (mem_size_w),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_ready_i  (mem_ready_i),
    .busy_o       (busy_o),
    .irq_o        (irq_o),
    .fetch_done_o (fetch_done_w),
    .abandon_o    (abandon_w)
  );

  assign mem_size_o = mem_size_w;

endmodule

// File: rtl/dma_unit_engine_chk.sv
module dma_unit_engine_chk import dma_unit_pkg::*; #(
  parameter  int ADDR_W = 16,
  parameter  int CNT_W  = 12,
  localparam int REC_W  = CTL_W + CNT_W + 2*ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic              desc_rd_en_o,
  input logic              desc_wr_en_o,
  input logic [REC_W-1:0]  desc_wdata_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [1:0]        mem_size_o,
  input logic              mem_ready_i,
  input logic              busy_o,
  input logic              irq_o,
  input logic              pending_w,
  input logic              fetch_done_w,
  input logic              abandon_w
);

  localparam int CNT_LO = CTL_W;

  // R1
  fetch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd_en_o |=> !desc_rd_en_o);

  // R1
  trig_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pending_w);

  // R2
  clear_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd_en_o |=> fetch_done_w);

  // R3
  abandon_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abandon_w |=> !mem_req_o && !desc_wr_en_o && !irq_o);

  // R7
  single_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en_o |=> !desc_wr_en_o && !busy_o);

  // R8
  irq_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> desc_wr_en_o && (desc_wdata_o[CNT_LO +: CNT_W] == '0));

  // R9
  busy_covers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
                                  && $stable(mem_we_o) && $stable(mem_size_o));

endmodule

bind dma_unit_engine dma_unit_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_i       (trig_i),
  .desc_rd_en_o (desc_rd_en_o),
  .desc_wr_en_o (desc_wr_en_o),
  .desc_wdata_o (desc_wdata_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_size_o   (mem_size_o),
  .mem_ready_i  (mem_ready_i),
  .busy_o       (busy_o),
  .irq_o        (irq_o),
  .pending_w    (pending_w),
  .fetch_done_w (fetch_done_w),
  .abandon_w    (abandon_w)
);

// File: tb/test_dma_unit_engine.sv
module test_dma_unit_engine;

  localparam int AW = 16;
  localparam int CW = 12;
  localparam int RW = 11 + CW + 2*AW;
  localparam int NV = 11;

  // {dst, src, count, dmode, smode, size, ptr16, stype, enable, burst}
  localparam logic [RW-1:0] VEC [NV] = '{
    {16'h0080, 16'h0010, 12'd3,   2'd1, 2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h0090, 16'h0020, 12'd1,   2'd0, 2'd1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h00A0, 16'h0030, 12'd2,   2'd1, 2'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h00B0, 16'h0040, 12'd1,   2'd3, 2'd1, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'h00B8, 16'h0044, 12'd4,   2'd1, 2'd2, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h00C0, 16'h0060, 12'd2,   2'd1, 2'd1, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h00C8, 16'h0010, 12'd2,   2'd1, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h00C8, 16'h0010, 12'd2,   2'd1, 2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1},
    {16'h00C8, 16'h0010, 12'd0,   2'd1, 2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h00D0, 16'h0070, 12'hFFF, 2'd1, 2'd1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h00E0, 16'h0040, 12'd7,   2'd0, 2'd3, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic          desc_rd_en, desc_wr_en;
  logic [RW-1:0] desc_rdata = '0;
  logic [RW-1:0] desc_wdata;
  logic          mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          busy, irq;

  always #5 clk = ~clk;

  dma_unit_engine #(.ADDR_W(AW), .CNT_W(CW)) i_dma_unit_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig),
    .desc_rd_en_o (desc_rd_en),
    .desc_rdata_i (desc_rdata),
    .desc_wr_en_o (desc_wr_en),
    .desc_wdata_o (desc_wdata),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_size_o   (mem_size),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (mem_rdata),
    .mem_ready_i  (mem_ready),
    .busy_o       (busy),
    .irq_o        (irq)
  );

  // ---------------- environment models ----------------
  logic [7:0]    mem [256];
  logic [RW-1:0] desc_mem = '0;
  logic          wait_ph = 1'b0;
  logic          init_req = 1'b0, load_req = 1'b0;
  logic [RW-1:0] load_val = '0;
  int fetch_cnt = 0, wb_cnt = 0, irq_cnt = 0, acc_cnt = 0, busy_cyc = 0;
  int hold_viol = 0, busy_viol = 0;
  logic          hold_pend = 1'b0;
  logic [AW-1:0] hold_addr = '0;
  logic          hold_we = 1'b0;
  logic [7:0]    ma;

  function automatic logic [7:0] init_byte(input logic [7:0] a);
    case (a)
      8'h40:   return 8'h50;
      8'h44:   return 8'h58;
      8'h45:   return 8'h00;
      default: return 8'(a * 8'd37 + 8'd11);
    endcase
  endfunction

  assign ma        = mem_addr[7:0];
  assign mem_rdata = {mem[8'(ma + 8'd3)], mem[8'(ma + 8'd2)], mem[8'(ma + 8'd1)], mem[ma]};
  assign mem_ready = mem_req && wait_ph;

  always @(posedge clk) begin
    wait_ph <= mem_req && !wait_ph;
    if (init_req)
      for (int j = 0; j < 256; j++) mem[j] <= init_byte(8'(j));
    else if (mem_req && mem_ready && mem_we)
      for (int k = 0; k < (mem_size == 2'd2 ? 4 : mem_size == 2'd1 ? 2 : 1); k++)
        mem[8'(ma + 8'(k))] <= mem_wdata[8*k +: 8];
    if (load_req) desc_mem <= load_val;
    if (desc_rd_en) begin
      desc_rdata <= desc_mem;
      fetch_cnt  <= fetch_cnt + 1;
    end
    if (desc_wr_en) begin
      desc_mem <= desc_wdata;
      wb_cnt   <= wb_cnt + 1;
    end
    if (irq) irq_cnt <= irq_cnt + 1;
    if (mem_req && mem_ready) acc_cnt <= acc_cnt + 1;
    if (busy) busy_cyc <= busy_cyc + 1;
    if (mem_req && !busy) busy_viol <= busy_viol + 1;
    if (hold_pend && (!mem_req || mem_addr != hold_addr || mem_we != hold_we))
      hold_viol <= hold_viol + 1;
    hold_pend <= mem_req && !mem_ready;
    hold_addr <= mem_addr;
    hold_we   <= mem_we;
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  logic [RW-1:0] v, exp_rec;
  logic          b_burst, b_en, b_st, b_p16;
  logic [2:0]    b_us;
  logic [1:0]    b_sm, b_dm;
  logic [CW-1:0] b_cnt;
  logic [AW-1:0] b_src, b_dst, b_real, b_src_n, b_dst_n;
  int            nb, f0, w0, i0, a0, bz0;
  bit            run_ok, data_ok;

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy && !irq && !mem_req && !desc_rd_en && !desc_wr_en, "R11", "outputs in reset",
        {busy, irq, mem_req, desc_rd_en, desc_wr_en}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(fetch_cnt == 0 && !busy && !mem_req, "R11", "idle without trigger", fetch_cnt, 0);

    // table-driven units
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      b_burst = v[0]; b_en = v[1]; b_st = v[2]; b_p16 = v[3];
      b_us = v[6:4]; b_sm = v[8:7]; b_dm = v[10:9];
      b_cnt = v[22:11]; b_src = v[38:23]; b_dst = v[54:39];
      nb = (b_us == 3'd1) ? 2 : (b_us == 3'd2) ? 4 : 1;
      run_ok = b_en && !b_burst && (b_cnt != 0);
      b_real = !b_st ? b_src :
               b_p16 ? {init_byte(8'(b_src + 16'd1)), init_byte(b_src[7:0])} :
                       {8'h00, init_byte(b_src[7:0])};
      b_src_n = (b_sm == 2'd1) ? 16'(b_src + 16'(nb)) : b_src;
      b_dst_n = (b_dm == 2'd1) ? 16'(b_dst + 16'(nb)) : b_dst;
      exp_rec = {b_dst_n, b_src_n, 12'(b_cnt - 12'd1), v[10:0]};

      init_req = 1'b1; load_req = 1'b1; load_val = v;
      @(negedge clk);
      init_req = 1'b0; load_req = 1'b0;
      f0 = fetch_cnt; w0 = wb_cnt; i0 = irq_cnt; a0 = acc_cnt; bz0 = busy_cyc;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      repeat (40) @(negedge clk);

      chk(fetch_cnt - f0 == 1, "R1", "one fetch per trigger", 64'(fetch_cnt - f0), 1);
      if (!run_ok) begin
        chk(acc_cnt == a0 && wb_cnt == w0 && irq_cnt == i0, "R3", "abandoned record quiet",
            64'(acc_cnt - a0 + wb_cnt - w0 + irq_cnt - i0), 0);
      end else begin
        chk(wb_cnt - w0 == 1 && desc_mem == exp_rec, "R7", "written-back record (R6 addresses)",
            64'(desc_mem), 64'(exp_rec));
        chk(irq_cnt - i0 == ((b_cnt == 12'd1) ? 1 : 0), "R8", "interrupt on last unit",
            64'(irq_cnt - i0), (b_cnt == 12'd1) ? 1 : 0);
        data_ok = 1'b1;
        for (int k = 0; k < nb; k++)
          if (mem[8'(b_dst[7:0] + 8'(k))] != init_byte(8'(b_real[7:0] + 8'(k)))) data_ok = 1'b0;
        chk(data_ok, b_st ? "R5" : "R4", "destination bytes",
            {mem[8'(b_dst[7:0] + 8'd3)], mem[8'(b_dst[7:0] + 8'd2)],
             mem[8'(b_dst[7:0] + 8'd1)], mem[b_dst[7:0]]},
            {init_byte(8'(b_real[7:0] + 8'd3)), init_byte(8'(b_real[7:0] + 8'd2)),
             init_byte(8'(b_real[7:0] + 8'd1)), init_byte(b_real[7:0])});
        if (nb < 4)
          chk(mem[8'(b_dst[7:0] + 8'(nb))] == init_byte(8'(b_dst[7:0] + 8'(nb))), "R4",
              "byte past unit untouched", mem[8'(b_dst[7:0] + 8'(nb))],
              init_byte(8'(b_dst[7:0] + 8'(nb))));
        chk(busy_cyc - bz0 >= 4 && !busy, "R9", "busy during unit, low after",
            64'(busy_cyc - bz0), 4);
      end
    end

    // R2 and R1: fetch timing and triggers merged during a unit
    v = VEC[0];
    init_req = 1'b1; load_req = 1'b1; load_val = v;
    @(negedge clk);
    init_req = 1'b0; load_req = 1'b0;
    f0 = fetch_cnt; w0 = wb_cnt;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(desc_rd_en, "R2", "fetch in cycle after trigger", desc_rd_en, 1);
    @(negedge clk);
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (60) @(negedge clk);
    chk(fetch_cnt - f0 == 2, "R1", "two triggers in flight merged", 64'(fetch_cnt - f0), 2);
    chk(wb_cnt - w0 == 2 && desc_mem[22:11] == 12'd1, "R2", "second unit ran, count",
        64'(desc_mem[22:11]), 1);
    chk(desc_mem[38:23] == 16'h0012 && desc_mem[54:39] == 16'h0082, "R6",
        "addresses after two byte units", {desc_mem[54:39], desc_mem[38:23]}, 32'h0082_0012);
    chk(mem[8'h81] == init_byte(8'h11), "R4", "second unit data", mem[8'h81], init_byte(8'h11));
    chk(hold_viol == 0, "R10", "request held until ready", 64'(hold_viol), 0);
    chk(busy_viol == 0 && !busy, "R9", "no request outside busy", 64'(busy_viol), 0);

    summary();
    $finish;
  end

endmodule